// File: doc/BRIEF.md
# Clear Channel Assessment Logic

This block decides whether the radio channel is busy and reports the answer to the media access controller on a single registered line. It draws on two sources of evidence. The first is energy detection: a received-energy level compared against a programmable threshold. The second is a carrier-sense flag kept by a small three-state machine.

The carrier-sense machine starts from an idle state. It arms as soon as the gain control reads unlocked. It then waits for the gain control to lock and for a signal-quality check to complete. A failing check returns the machine to idle. A passing check moves it to a tracking state, which lasts until the reception ends or the signal is lost.

A two-bit mode field selects how the two terms are combined. An override input forces the line to read clear, so that a transmitter may ignore the channel state altogether.

Top module: `cca_detect`

## Requirements
- R1: After reset, `busy` and `cs_active` are both 0.
- R2: Energy detect is true when `energy_lvl` is greater than or equal to `energy_thresh`, compared as unsigned values.
- R3: While idle (`cs_active` = 0), a cycle with `agc_locked` = 0 sets `cs_active` on the next edge.
- R4: Once armed and not yet tracking, `cs_active` stays 1 until a cycle in which both `agc_locked` = 1 and `sq_done` = 1. An `sq_done` pulse seen while unlocked is ignored.
- R5: When `sq_done` = 1 and `sq_pass` = 0 are seen while armed and locked, `cs_active` returns to 0 on the next edge.
- R6: When `sq_done` = 1 and `sq_pass` = 1 are seen while armed and locked, the machine enters tracking. It keeps `cs_active` at 1, ignoring further quality results and unlock, until `rx_end` or `sig_lost` is high. It then clears on the next edge.
- R7: `mode` selects the combination of the two terms: 0 gives energy only, 1 gives carrier sense only, 2 gives energy AND carrier sense, and 3 gives energy OR carrier sense.
- R8: With `ignore_busy` = 1, `busy` is 0 on the next edge whatever the other inputs are. The carrier-sense state keeps evolving underneath.
- R9: `busy` is registered. It reflects the inputs present before a rising edge, including the carrier-sense state that this edge produces, and it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_lvl | input | LVL_W | Measured received energy |
| energy_thresh | input | LVL_W | Energy detect threshold |
| agc_locked | input | 1 | Gain control lock status |
| sq_done | input | 1 | Signal-quality check completes this cycle |
| sq_pass | input | 1 | Signal-quality result, valid with `sq_done` |
| rx_end | input | 1 | End-of-reception pulse |
| sig_lost | input | 1 | Loss-of-signal indication |
| mode | input | 2 | Combination select |
| ignore_busy | input | 1 | Forces `busy` to read clear |
| cs_active | output | 1 | Carrier-sense flag |
| busy | output | 1 | Registered channel-busy indication |

## Verification
The assertions assume that `sq_pass` matters only in a cycle where `sq_done` is high. They also assume that all inputs settle before each rising edge. A quality pulse that arrives while the gain control is still unlocked is legal, and it is expected to be dropped. The stimulus changes every input only on the falling edge, and it issues quality pulses both while locked and while unlocked. It sweeps every level, threshold, mode and override combination of a 4-bit configuration in each of the three carrier-sense states.

// File: rtl/cca_detect.sv
module cca_detect #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] energy_lvl,
  input  logic [LVL_W-1:0] energy_thresh,
  input  logic             agc_locked,
  input  logic             sq_done,
  input  logic             sq_pass,
  input  logic             rx_end,
  input  logic             sig_lost,
  input  logic [1:0]       mode,
  input  logic             ignore_busy,
  output logic             cs_active,
  output logic             busy
);

  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_WAIT  = 2'd1;
  localparam logic [1:0] S_TRACK = 2'd2;

  logic [1:0] st, st_nxt;
  logic       ed, cs_nxt, busy_nxt;

  assign ed = energy_lvl >= energy_thresh;

  always_comb begin
    st_nxt = st;
    case (st)
      S_IDLE:  if (!agc_locked) st_nxt = S_WAIT;
      S_WAIT:  if (agc_locked && sq_done) st_nxt = sq_pass ? S_TRACK : S_IDLE;
      S_TRACK: if (rx_end || sig_lost) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  assign cs_nxt = st_nxt != S_IDLE;

  always_comb begin
    case (mode)
      2'd0:    busy_nxt = ed;
      2'd1:    busy_nxt = cs_nxt;
      2'd2:    busy_nxt = ed & cs_nxt;
      default: busy_nxt = ed | cs_nxt;
    endcase
    if (ignore_busy) busy_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      busy <= 1'b0;
    end else begin
      st   <= st_nxt;
      busy <= busy_nxt;
    end
  end

  assign cs_active = st != S_IDLE;

endmodule

// File: rtl/cca_detect_chk.sv
module cca_detect_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] energy_lvl,
  input logic [LVL_W-1:0] energy_thresh,
  input logic             agc_locked,
  input logic             sq_done,
  input logic             sq_pass,
  input logic             rx_end,
  input logic             sig_lost,
  input logic [1:0]       mode,
  input logic             ignore_busy,
  input logic             cs_active,
  input logic             busy,
  input logic [1:0]       st
);

  logic tracking;
  assign tracking = st == 2'd2;

  assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active && !agc_locked |=> cs_active);

  assert_hold_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && !agc_locked && !tracking |=> cs_active && !tracking);

  assert_fail_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && !tracking && agc_locked && sq_done && !sq_pass |=> !cs_active);

  assert_pass_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && !tracking && agc_locked && sq_done && sq_pass |=> tracking);

  assert_track_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tracking && (rx_end || sig_lost) |=> !cs_active);

  assert_energy_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 && !ignore_busy |=> busy == $past(energy_lvl >= energy_thresh));

  assert_cs_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && !ignore_busy |=> busy == cs_active);

  assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_busy |=> !busy);

endmodule

bind cca_detect cca_detect_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .energy_lvl(energy_lvl), .energy_thresh(energy_thresh),
  .agc_locked(agc_locked), .sq_done(sq_done), .sq_pass(sq_pass), .rx_end(rx_end),
  .sig_lost(sig_lost), .mode(mode), .ignore_busy(ignore_busy),
  .cs_active(cs_active), .busy(busy), .st(st)
);

// File: tb/cca_detect_bench.sv
module cca_detect_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] energy_lvl = '0, energy_thresh = '0;
  logic         agc_locked = 1'b1, sq_done = 1'b0, sq_pass = 1'b0;
  logic         rx_end = 1'b0, sig_lost = 1'b0, ignore_busy = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         cs_active, busy;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cca_detect #(.LVL_W(W)) u_cca_detect (
    .clk(clk), .rst_n(rst_n), .energy_lvl(energy_lvl), .energy_thresh(energy_thresh),
    .agc_locked(agc_locked), .sq_done(sq_done), .sq_pass(sq_pass), .rx_end(rx_end),
    .sig_lost(sig_lost), .mode(mode), .ignore_busy(ignore_busy),
    .cs_active(cs_active), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model(input logic [1:0] m, input logic e, input logic c, input logic ig);
    logic r;
    if (m == 2'd0) r = e;
    else if (m == 2'd1) r = c;
    else if (m == 2'd2) r = e & c;
    else r = e | c;
    return ig ? 1'b0 : r;
  endfunction

  task automatic step; @(negedge clk); endtask

  task automatic sweep(input logic cs_exp, input string req);
    for (int m = 0; m < 4; m++)
      for (int ig = 0; ig < 2; ig++)
        for (int l = 0; l < 16; l++)
          for (int t = 0; t < 16; t++) begin
            mode = m[1:0]; ignore_busy = ig[0];
            energy_lvl = l[W-1:0]; energy_thresh = t[W-1:0];
            step();
            chk(req, busy, model(m[1:0], l >= t, cs_exp, ig[0]));
            chk(req, cs_active, cs_exp);
          end
    ignore_busy = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    chk("R1 busy", busy, 1'b0);
    chk("R1 cs", cs_active, 1'b0);
    rst_n = 1'b1;
    step();

    sweep(1'b0, "R2/R7/R8 idle");

    mode = 2'd1; energy_lvl = 0; energy_thresh = 4'd15;
    agc_locked = 1'b0; step();
    chk("R3 cs", cs_active, 1'b1);
    chk("R9 busy same edge", busy, 1'b1);
    sq_done = 1'b1; sq_pass = 1'b0; step();
    chk("R4 unlocked pulse ignored", cs_active, 1'b1);
    sq_done = 1'b0; agc_locked = 1'b1;
    sweep(1'b1, "R4/R7/R8 armed");

    mode = 2'd1; sq_done = 1'b1; sq_pass = 1'b0; step();
    sq_done = 1'b0;
    chk("R5 cs", cs_active, 1'b0);
    chk("R5 busy", busy, 1'b0);
    step();
    chk("R5 stays idle", cs_active, 1'b0);

    agc_locked = 1'b0; step();
    agc_locked = 1'b1; sq_done = 1'b1; sq_pass = 1'b1; step();
    sq_done = 1'b0;
    chk("R6 enter", cs_active, 1'b1);
    sq_done = 1'b1; sq_pass = 1'b0; agc_locked = 1'b0; step();
    sq_done = 1'b0; agc_locked = 1'b1;
    chk("R6 fail ignored in track", cs_active, 1'b1);
    sweep(1'b1, "R6/R7/R8 tracking");

    mode = 2'd1; rx_end = 1'b1; step();
    rx_end = 1'b0;
    chk("R6 rx_end", cs_active, 1'b0);
    chk("R6 rx_end busy", busy, 1'b0);

    agc_locked = 1'b0; step();
    agc_locked = 1'b1; sq_done = 1'b1; sq_pass = 1'b1; step();
    sq_done = 1'b0;
    sig_lost = 1'b1; step();
    sig_lost = 1'b0;
    chk("R6 sig_lost", cs_active, 1'b0);

    mode = 2'd0; energy_thresh = 4'd5; energy_lvl = 4'd5; step();
    chk("R2 equal", busy, 1'b1);
    energy_lvl = 4'd4;
    #1 chk("R9 held between edges", busy, 1'b1);
    step();
    chk("R9 updated", busy, 1'b0);

    ignore_busy = 1'b1; agc_locked = 1'b0; step();
    chk("R8 forced", busy, 1'b0);
    chk("R8 state evolves", cs_active, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule